// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block holds the digital counting stages that sit around a frequency synthesizer loop. Everything runs on one system clock. The oscillator and VCO edges come in as single-cycle tick enables, and each divider answers with a single-cycle strobe. Three stages do the dividing:

- A reference stage turns oscillator ticks into the comparison tick that goes to the phase detector.
- A feedback stage turns VCO ticks into the tick that closes the loop.
- A post stage turns VCO ticks into the synthesizer output, and also drives a square-wave toggle.

A final halving stage makes the bus-rate strobe. It counts post-stage strobes when the synthesizer is selected and oscillator ticks when it is not.

The block carries no data stream. All of its pins are plain control inputs and strobe outputs, with no valid/ready handshake and no back-pressure. Divider settings may change at any time. A stage takes a new setting only when it finishes its current period. The analog loop, the phase comparison and lock detection all sit outside this block.

Top module: `pll_div_chain`

## Requirements
- R1: The reference stage sends one `ref_stb` pulse for every `ref_div`+1 oscillator ticks, so ratios run from 1 to 64. The pulse is high for exactly the one clock cycle that follows the tick that completes the period.
- R2: The feedback stage sends one `fb_stb` pulse for every 2×(`syn_div`+1) VCO ticks, so ratios run from 2 to 128. Its timing matches R1.
- R3: When `post_div` is 0, `pll_stb` pulses once for every VCO tick, in the cycle after that tick.
- R4: When `post_div` is N (1 to 31), `pll_stb` pulses once for every 2×N VCO ticks.
- R5: The bus stage pulses `bus_stb` once for every two source events. The source is `pll_stb` when `pll_sel` is 1 and `osc_tick` when `pll_sel` is 0. `bus_stb` is never high in two cycles in a row.
- R6: A setting that changes in the middle of a period does not shorten or stretch that period. The new setting applies from the next period onward.
- R7: While synchronous reset `rst` is high, all outputs are 0. After release, each stage sends its first strobe only when a full period of ticks has arrived.
- R8: When `post_div` is N > 0, `pll_tog` is low for the first N VCO ticks of each output period and high for the other N ticks. It starts low after reset and changes only in the cycle after a VCO tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle enable per oscillator edge |
| vco_tick | input | 1 | One-cycle enable per VCO edge |
| ref_div | input | 6 | Reference setting, ratio = value+1 |
| syn_div | input | 6 | Feedback setting, ratio = 2×(value+1) |
| post_div | input | 5 | Post setting, ratio 1 when 0, else 2×value |
| pll_sel | input | 1 | 1: bus counts synthesizer strobes; 0: oscillator ticks |
| ref_stb | output | 1 | Reference tick strobe |
| fb_stb | output | 1 | Feedback tick strobe |
| pll_stb | output | 1 | Synthesizer output strobe |
| pll_tog | output | 1 | Square-wave form of the post output |
| bus_stb | output | 1 | Bus-rate strobe |

## Verification
A counter that reloads wrongly or drops a period shows up as the wrong number of strobes. This shows within a single period of the affected stage, which is at most 128 ticks. The bench therefore counts strobes over windows that are whole multiples of the expected ratio.

A post stage that takes a new setting at the wrong point shows up as a first strobe at the wrong tick number. A post stage with a bad half-period shows up as a wrong high-time count on `pll_tog`, and this appears within one output period.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  // Which event stream the bus halving stage counts.
  typedef enum logic {
    BUS_FROM_OSC = 1'b0,
    BUS_FROM_PLL = 1'b1
  } bus_src_e;
endpackage

// File: rtl/pll_div_stage.sv
// Down-counter divider. The counter reloads from `load` (ratio minus one)
// only at terminal count, so a new setting starts with the next period.
module pll_div_stage #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] load,
  output logic          stb
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= load;
      stb <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (adv) begin
        if (cnt == '0) begin
          stb <= 1'b1;
          cnt <= load;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  // R1/R2: a strobe always follows an advance.
  assert_stb_after_tick_R1: assert property (@(posedge clk) disable iff (rst)
    stb |-> $past(adv));

  // R6: the counter jumps (anything other than hold or step down) only when it reloads.
  assert_reload_only_at_terminal_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt) && cnt != ($past(cnt) - CW'(1))) |-> stb);
endmodule

// File: rtl/pll_post_div.sv
// Post divider built as a half-period counter plus a phase bit. The
// setting is held for a whole output period, which keeps the toggle at 50%.
module pll_post_div #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [PW-1:0] setting,
  output logic          stb,
  output logic          tog
);
  logic [PW-1:0] hold;
  logic [PW-1:0] cnt;
  logic          phase;

  function automatic logic [PW-1:0] half_load(input logic [PW-1:0] v);
    return (v == '0) ? '0 : v - PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= setting;
      cnt   <= half_load(setting);
      phase <= 1'b0;
      stb   <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (tick) begin
        if (cnt != '0) begin
          cnt <= cnt - PW'(1);
        end else if (hold == '0 || phase) begin
          // End of a full output period: take the new setting.
          stb   <= 1'b1;
          hold  <= setting;
          cnt   <= half_load(setting);
          phase <= (hold == '0 && setting == '0) ? ~phase : 1'b0;
        end else begin
          // End of the low half: start the high half.
          phase <= 1'b1;
          cnt   <= half_load(hold);
        end
      end
    end
  end

  assign tog = phase;

  assert_stb_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
    stb |-> $past(tick));

  assert_tog_moves_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> $past(tick));

  assert_setting_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(hold) |-> stb);
endmodule

// File: rtl/pll_bus_half.sv
// Divide-by-two on the selected event stream.
module pll_bus_half
  import pll_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pll_sel,
  input  logic osc_tick,
  input  logic pll_stb,
  output logic bus_stb
);
  bus_src_e src_sel;
  logic     src;
  logic     half;

  assign src_sel = pll_sel ? BUS_FROM_PLL : BUS_FROM_OSC;
  assign src     = (src_sel == BUS_FROM_PLL) ? pll_stb : osc_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      half    <= 1'b0;
      bus_stb <= 1'b0;
    end else begin
      bus_stb <= src & half;
      if (src) half <= ~half;
    end
  end

  assert_bus_after_source_R5: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> $past(src));

  assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (rst)
    bus_stb |=> !bus_stb);
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int REF_W  = 6,
  parameter int SYN_W  = 6,
  parameter int POST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              vco_tick,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [SYN_W-1:0]  syn_div,
  input  logic [POST_W-1:0] post_div,
  input  logic              pll_sel,
  output logic              ref_stb,
  output logic              fb_stb,
  output logic              pll_stb,
  output logic              pll_tog,
  output logic              bus_stb
);
  // Feedback ratio 2*(s+1) minus one is {s, 1}: one extra bit.
  localparam int FB_W = SYN_W + 1;

  logic [FB_W-1:0] fb_load;
  assign fb_load = {syn_div, 1'b1};

  pll_div_stage #(.CW(REF_W)) u_ref (
    .clk(clk), .rst(rst), .adv(osc_tick), .load(ref_div), .stb(ref_stb)
  );

  pll_div_stage #(.CW(FB_W)) u_fb (
    .clk(clk), .rst(rst), .adv(vco_tick), .load(fb_load), .stb(fb_stb)
  );

  pll_post_div #(.PW(POST_W)) u_post (
    .clk(clk), .rst(rst), .tick(vco_tick), .setting(post_div),
    .stb(pll_stb), .tog(pll_tog)
  );

  pll_bus_half u_bus (
    .clk(clk), .rst(rst), .pll_sel(pll_sel), .osc_tick(osc_tick),
    .pll_stb(pll_stb), .bus_stb(bus_stb)
  );

  assert_quiet_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(ref_stb | fb_stb | pll_stb | bus_stb | pll_tog));
endmodule

// File: tb/sim_pll_div_chain.sv
`timescale 1ns/1ps
module sim_pll_div_chain;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0, vco_tick = 1'b0;
  logic [5:0] ref_div = '0, syn_div = '0;
  logic [4:0] post_div = '0;
  logic pll_sel = 1'b0;
  logic ref_stb, fb_stb, pll_stb, pll_tog, bus_stb;

  int checks = 0, failures = 0;
  int n_ref = 0, n_fb = 0, n_pll = 0, n_bus = 0;
  int tog_hi = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_div_chain u0 (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .vco_tick(vco_tick),
    .ref_div(ref_div), .syn_div(syn_div), .post_div(post_div), .pll_sel(pll_sel),
    .ref_stb(ref_stb), .fb_stb(fb_stb), .pll_stb(pll_stb), .pll_tog(pll_tog),
    .bus_stb(bus_stb)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ref_stb) n_ref++;
      if (fb_stb)  n_fb++;
      if (pll_stb) n_pll++;
      if (bus_stb) n_bus++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; osc_tick = 1'b0; vco_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_ref = 0; n_fb = 0; n_pll = 0; n_bus = 0; tog_hi = 0;
  endtask

  // One tick; pll_tog is sampled before the tick takes effect.
  task automatic pulse(input bit o, input bit v);
    @(negedge clk);
    if (pll_tog) tog_hi++;
    osc_tick = o; vco_tick = v;
    @(negedge clk);
    osc_tick = 1'b0; vco_tick = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_R7();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 outputs low in reset", int'({ref_stb, fb_stb, pll_stb, pll_tog, bus_stb}), 0);
    // Feedback ratio 6: nothing after 5 ticks, first strobe on the 6th.
    syn_div = 6'd2; post_div = 5'd1; do_reset();
    repeat (5) pulse(1'b0, 1'b1);
    settle();
    check("R7 no fb strobe before full period", n_fb, 0);
    pulse(1'b0, 1'b1); settle();
    check("R7 first fb strobe after full period", n_fb, 1);
  endtask

  task automatic t_ref_R1(input int r);
    ref_div = 6'(r); do_reset();
    repeat (200) pulse(1'b1, 1'b0);
    settle();
    check($sformatf("R1 ref count div=%0d", r), n_ref, 200 / (r + 1));
  endtask

  task automatic t_fb_R2(input int s);
    syn_div = 6'(s); do_reset();
    repeat (300) pulse(1'b0, 1'b1);
    settle();
    check($sformatf("R2 fb count div=%0d", s), n_fb, 300 / (2 * (s + 1)));
  endtask

  task automatic t_post_bypass_R3();
    post_div = 5'd0; do_reset();
    repeat (50) pulse(1'b0, 1'b1);
    settle();
    check("R3 bypass count", n_pll, 50);
  endtask

  task automatic t_post_R4(input int n);
    post_div = 5'(n); do_reset();
    repeat (8 * n) pulse(1'b0, 1'b1);
    settle();
    check($sformatf("R4 post count N=%0d", n), n_pll, 4);
    check($sformatf("R8 toggle high ticks N=%0d", n), tog_hi, 4 * n);
  endtask

  task automatic t_bus_R5();
    post_div = 5'd3; pll_sel = 1'b1; do_reset();
    repeat (60) pulse(1'b0, 1'b1);
    settle();
    check("R5 pll count", n_pll, 10);
    check("R5 bus from pll", n_bus, 5);
    pll_sel = 1'b0; do_reset();
    repeat (41) pulse(1'b1, 1'b0);
    settle();
    check("R5 bus from osc", n_bus, 20);
  endtask

  task automatic t_midchange_R6();
    int first;
    // Reference ratio 10, switched to ratio 2 after 3 ticks.
    ref_div = 6'd9; do_reset();
    repeat (3) pulse(1'b1, 1'b0);
    ref_div = 6'd1;
    first = 0;
    for (int i = 4; i <= 12; i++) begin
      @(negedge clk);
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      if (ref_stb && first == 0) first = i;
    end
    settle();
    check("R6 ref first strobe tick", first, 10);
    check("R6 ref new ratio applied", n_ref, 2);
    // Post ratio 4, switched to 10 after one tick: strobes at ticks 4 and 14.
    post_div = 5'd2; do_reset();
    pulse(1'b0, 1'b1);
    post_div = 5'd5;
    repeat (12) pulse(1'b0, 1'b1);
    settle();
    check("R6 post old period kept", n_pll, 1);
    pulse(1'b0, 1'b1); settle();
    check("R6 post new period", n_pll, 2);
  endtask

  initial begin
    t_reset_R7();
    t_ref_R1(0);
    t_ref_R1(63);
    t_ref_R1($urandom_range(1, 62));
    t_fb_R2(0);
    t_fb_R2(63);
    t_fb_R2($urandom_range(1, 62));
    t_post_bypass_R3();
    t_post_R4(1);
    t_post_R4(31);
    t_post_R4($urandom_range(2, 30));
    t_bus_R5();
    t_midchange_R6();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule